// File: doc/BRIEF.md
# SMBus Host Command Sequencer

This core is the command engine of an SMBus host controller. Software loads a target address, a command byte and two data bytes into a small byte-wide register file. It then writes one control byte, which both chooses the transaction kind and starts it. The core walks through the bus phases for that kind over a byte-level bus-master handshake. The phases are start, write byte, read byte and stop. A separate bit-level engine, outside this core, performs each phase and reports acknowledge, lost arbitration and received data.

Progress and outcome appear in a status byte. A live busy bit is set while a transaction runs. Success, no-acknowledge, lost arbitration and abort each have their own sticky flag, and software clears a flag by writing 1 to it. A kill bit in the control byte aborts a running transaction at once. The supported kinds are Quick, Byte, Byte-Data and Word-Data, each as a read or a write. Other kind codes are accepted and then reported as a device error.

Top module: `smbh_host`

## Requirements
- R1: After reset the status byte reads 0, the control byte reads 0, and phy_req_o is low. phy_req_o is never high while the busy bit (status bit 0) is clear.
- R2: The address register is at offset 4 (7-bit target in bits 7:1, read/write bit in bit 0). The command register is at offset 3, data0 at offset 5 and data1 at offset 6. Each reads back what was written while idle. Offsets without a register read 0.
- R3: A write to offset 2 with bit 6 set starts a transaction while idle. Bits 4:2 of that byte give the kind: 0 Quick, 1 Byte, 2 Byte-Data, 3 Word-Data. The control byte then reads back the kind in bits 4:2.
- R4: While busy, a start request is ignored and the kind is kept. Writes to the address, command and data registers are also ignored.
- R5: Bus phases are coded on phy_op_o as 0 start, 1 write byte, 2 read byte, 3 stop. The write sequences are as follows. Quick sends start, address, stop. Byte sends start, address, command, stop. Byte-Data adds data0 after the command. Word-Data adds data0 and then data1.
- R6: A Byte read sends start, address, one read, stop. Byte-Data and Word-Data reads send start, the address with bit 0 cleared, the command, a repeated start, the address with bit 0 set, the reads, then stop. The first byte read lands in data0 and the second in data1. phy_last_o marks only the final read.
- R7: On success the busy bit clears and the done flag (status bit 1) sets on the same clock edge. The done flag is set by nothing else.
- R8: A no-acknowledge on a written byte ends the transfer with a stop. The device-error flag (status bit 2) is set, busy clears, and the done flag stays clear.
- R9: Lost arbitration on any phase sets the bus-error flag (status bit 3) and clears busy. No further phase is requested.
- R10: A control write with bit 1 set while busy drops phy_req_o and clears busy on the next edge, and sets the failed flag (status bit 4). While idle the same write changes nothing.
- R11: Writing 1 to status bits 1 to 4 clears those flags, and writing 0 leaves them. The busy bit cannot be written.
- R12: Kind codes 4 to 7 (for example control value 0x50) make no bus request and end with the device-error flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | AW | Register offset |
| reg_wdata_i | input | DW | Register write data |
| reg_rdata_o | output | DW | Register read data for reg_addr_i |
| phy_req_o | output | 1 | A bus phase is requested |
| phy_op_o | output | 2 | Phase code: 0 start, 1 write, 2 read, 3 stop |
| phy_wdata_o | output | DW | Byte to send in a write phase |
| phy_last_o | output | 1 | This read is the final one (master does not acknowledge) |
| phy_done_i | input | 1 | One-cycle pulse: requested phase finished |
| phy_nack_i | input | 1 | With phy_done_i: written byte was not acknowledged |
| phy_arb_lost_i | input | 1 | With phy_done_i: arbitration was lost |
| phy_rdata_i | input | DW | With phy_done_i: byte received in a read phase |

## Verification
The properties assume the bit-level engine pulses phy_done_i for exactly one cycle, and only while phy_req_o is high. They also assume no-acknowledge is reported only for write phases. The bench's responder holds to this: it answers each new request once, after a programmable latency, and drops any pending answer when the request falls. No-acknowledge is injected only at an index that the expected phase list shows to be a write, and a kill is issued only between responses, so an abort never races a done pulse.

// File: rtl/smbh_pkg.sv
package smbh_pkg;
  localparam int unsigned OFF_STAT = 0;
  localparam int unsigned OFF_CTRL = 2;
  localparam int unsigned OFF_CMD  = 3;
  localparam int unsigned OFF_ADDR = 4;
  localparam int unsigned OFF_D0   = 5;
  localparam int unsigned OFF_D1   = 6;

  localparam int unsigned CTRL_KILL  = 1;
  localparam int unsigned CTRL_START = 6;
  localparam int unsigned KIND_LSB   = 2;
  localparam int unsigned KIND_W     = 3;
  localparam int unsigned KIND_MAX   = 3;
  localparam int unsigned NFLAG      = 4;
  localparam int unsigned IDX_W      = 3;

  typedef enum logic [1:0] {
    PHY_START = 2'd0,
    PHY_WR    = 2'd1,
    PHY_RD    = 2'd2,
    PHY_STOP  = 2'd3
  } phy_op_e;

  typedef enum logic [2:0] {
    SRC_ADDR   = 3'd0,
    SRC_ADDR_W = 3'd1,
    SRC_ADDR_R = 3'd2,
    SRC_CMD    = 3'd3,
    SRC_D0     = 3'd4,
    SRC_D1     = 3'd5
  } src_e;

  typedef struct packed {
    phy_op_e op;
    src_e    src;
    logic    last;
  } step_t;

  function automatic step_t mk(phy_op_e o, src_e s, logic l);
    step_t r;
    r.op = o; r.src = s; r.last = l;
    return r;
  endfunction

  // phase list per kind and direction; the entry past the end is always stop
  function automatic step_t seq_step(logic [1:0] kind, logic rd, logic [IDX_W-1:0] idx);
    step_t s;
    s = mk(PHY_STOP, SRC_ADDR, 1'b0);
    case ({kind, rd})
      3'b000, 3'b001: case (idx)
        3'd0: s = mk(PHY_START, SRC_ADDR, 1'b0);
        3'd1: s = mk(PHY_WR, SRC_ADDR, 1'b0);
        default: ;
      endcase
      3'b010: case (idx)
        3'd0: s = mk(PHY_START, SRC_ADDR, 1'b0);
        3'd1: s = mk(PHY_WR, SRC_ADDR, 1'b0);
        3'd2: s = mk(PHY_WR, SRC_CMD, 1'b0);
        default: ;
      endcase
      3'b011: case (idx)
        3'd0: s = mk(PHY_START, SRC_ADDR, 1'b0);
        3'd1: s = mk(PHY_WR, SRC_ADDR, 1'b0);
        3'd2: s = mk(PHY_RD, SRC_D0, 1'b1);
        default: ;
      endcase
      3'b100: case (idx)
        3'd0: s = mk(PHY_START, SRC_ADDR, 1'b0);
        3'd1: s = mk(PHY_WR, SRC_ADDR, 1'b0);
        3'd2: s = mk(PHY_WR, SRC_CMD, 1'b0);
        3'd3: s = mk(PHY_WR, SRC_D0, 1'b0);
        default: ;
      endcase
      3'b101: case (idx)
        3'd0: s = mk(PHY_START, SRC_ADDR, 1'b0);
        3'd1: s = mk(PHY_WR, SRC_ADDR_W, 1'b0);
        3'd2: s = mk(PHY_WR, SRC_CMD, 1'b0);
        3'd3: s = mk(PHY_START, SRC_ADDR, 1'b0);
        3'd4: s = mk(PHY_WR, SRC_ADDR_R, 1'b0);
        3'd5: s = mk(PHY_RD, SRC_D0, 1'b1);
        default: ;
      endcase
      3'b110: case (idx)
        3'd0: s = mk(PHY_START, SRC_ADDR, 1'b0);
        3'd1: s = mk(PHY_WR, SRC_ADDR, 1'b0);
        3'd2: s = mk(PHY_WR, SRC_CMD, 1'b0);
        3'd3: s = mk(PHY_WR, SRC_D0, 1'b0);
        3'd4: s = mk(PHY_WR, SRC_D1, 1'b0);
        default: ;
      endcase
      default: case (idx)
        3'd0: s = mk(PHY_START, SRC_ADDR, 1'b0);
        3'd1: s = mk(PHY_WR, SRC_ADDR_W, 1'b0);
        3'd2: s = mk(PHY_WR, SRC_CMD, 1'b0);
        3'd3: s = mk(PHY_START, SRC_ADDR, 1'b0);
        3'd4: s = mk(PHY_WR, SRC_ADDR_R, 1'b0);
        3'd5: s = mk(PHY_RD, SRC_D0, 1'b0);
        3'd6: s = mk(PHY_RD, SRC_D1, 1'b1);
        default: ;
      endcase
    endcase
    return s;
  endfunction
endpackage

// File: rtl/smbh_regs.sv
module smbh_regs
  import smbh_pkg::*;
#(
  parameter int unsigned DW = 8,
  parameter int unsigned AW = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [AW-1:0]     addr_i,
  input  logic [DW-1:0]     wdata_i,
  output logic [DW-1:0]     rdata_o,
  input  logic              busy_i,
  input  logic              ev_ok_i,
  input  logic              ev_dev_i,
  input  logic              ev_bus_i,
  input  logic              ev_fail_i,
  input  logic              cap0_i,
  input  logic              cap1_i,
  input  logic [DW-1:0]     cap_data_i,
  output logic              start_o,
  output logic              kill_o,
  output logic [KIND_W-1:0] kind_o,
  output logic [DW-1:0]     adr_o,
  output logic [DW-1:0]     cmd_o,
  output logic [DW-1:0]     d0_o,
  output logic [DW-1:0]     d1_o,
  output logic [DW-1:0]     stat_o
);
  logic wr_stat, wr_ctrl, wr_cmd, wr_adr, wr_d0, wr_d1;
  logic [NFLAG-1:0] set_vec, flag_q;

  assign wr_stat = we_i && (addr_i == AW'(OFF_STAT));
  assign wr_ctrl = we_i && (addr_i == AW'(OFF_CTRL));
  assign wr_cmd  = we_i && (addr_i == AW'(OFF_CMD)) && !busy_i;
  assign wr_adr  = we_i && (addr_i == AW'(OFF_ADDR)) && !busy_i;
  assign wr_d0   = we_i && (addr_i == AW'(OFF_D0)) && !busy_i;
  assign wr_d1   = we_i && (addr_i == AW'(OFF_D1)) && !busy_i;

  assign kill_o  = wr_ctrl && wdata_i[CTRL_KILL];
  assign start_o = wr_ctrl && wdata_i[CTRL_START] && !wdata_i[CTRL_KILL] && !busy_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      kind_o <= '0;
      adr_o  <= '0;
      cmd_o  <= '0;
      d0_o   <= '0;
      d1_o   <= '0;
    end else begin
      if (start_o) kind_o <= wdata_i[KIND_LSB +: KIND_W];
      if (wr_adr)  adr_o  <= wdata_i;
      if (wr_cmd)  cmd_o  <= wdata_i;
      if (wr_d0)       d0_o <= wdata_i;
      else if (cap0_i) d0_o <= cap_data_i;
      if (wr_d1)       d1_o <= wdata_i;
      else if (cap1_i) d1_o <= cap_data_i;
    end
  end

  assign set_vec = {ev_fail_i, ev_bus_i, ev_dev_i, ev_ok_i};

  // sticky flags at status bits 1..NFLAG; a set wins over a clear in the same cycle
  for (genvar g = 0; g < NFLAG; g++) begin : g_flag
    logic f_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                       f_q <= 1'b0;
      else if (set_vec[g])               f_q <= 1'b1;
      else if (wr_stat && wdata_i[g+1])  f_q <= 1'b0;
    end
    assign flag_q[g] = f_q;
  end

  assign stat_o = DW'({flag_q, busy_i});

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      AW'(OFF_STAT): rdata_o = stat_o;
      AW'(OFF_CTRL): rdata_o = DW'({kind_o, 2'b00});
      AW'(OFF_CMD):  rdata_o = cmd_o;
      AW'(OFF_ADDR): rdata_o = adr_o;
      AW'(OFF_D0):   rdata_o = d0_o;
      AW'(OFF_D1):   rdata_o = d1_o;
      default:       rdata_o = '0;
    endcase
  end

  p_kind_held_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |=> $stable(kind_o));
  p_adr_held_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |=> $stable(adr_o));
  p_w1c_dev_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_stat && wdata_i[2] && !ev_dev_i) |=> !stat_o[2]);
endmodule

// File: rtl/smbh_seq.sv
module smbh_seq
  import smbh_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              kill_i,
  input  logic [KIND_W-1:0] kind_i,
  input  logic [DW-1:0]     adr_i,
  input  logic [DW-1:0]     cmd_i,
  input  logic [DW-1:0]     d0_i,
  input  logic [DW-1:0]     d1_i,
  output logic              phy_req_o,
  output logic [1:0]        phy_op_o,
  output logic [DW-1:0]     phy_wdata_o,
  output logic              phy_last_o,
  input  logic              phy_done_i,
  input  logic              phy_nack_i,
  input  logic              phy_arb_lost_i,
  input  logic [DW-1:0]     phy_rdata_i,
  output logic              busy_o,
  output logic              ev_ok_o,
  output logic              ev_dev_o,
  output logic              ev_bus_o,
  output logic              ev_fail_o,
  output logic              cap0_o,
  output logic              cap1_o,
  output logic [DW-1:0]     cap_data_o
);
  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_ESTOP} st_e;

  st_e              st_q, st_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  step_t            cur;
  logic             unsup, run, rd_ok;

  assign unsup = kind_i > KIND_W'(KIND_MAX);
  assign cur   = seq_step(kind_i[1:0], adr_i[0], idx_q);
  assign run   = (st_q == ST_RUN);

  always_comb begin
    st_d      = st_q;
    idx_d     = idx_q;
    ev_ok_o   = 1'b0;
    ev_dev_o  = 1'b0;
    ev_bus_o  = 1'b0;
    ev_fail_o = 1'b0;
    case (st_q)
      ST_IDLE: if (start_i) begin
        st_d  = ST_RUN;
        idx_d = '0;
      end
      ST_RUN: begin
        if (kill_i) begin
          st_d = ST_IDLE; ev_fail_o = 1'b1;
        end else if (unsup) begin
          st_d = ST_IDLE; ev_dev_o = 1'b1;
        end else if (phy_done_i) begin
          if (phy_arb_lost_i) begin
            st_d = ST_IDLE; ev_bus_o = 1'b1;
          end else if (cur.op == PHY_WR && phy_nack_i) begin
            st_d = ST_ESTOP;
          end else if (cur.op == PHY_STOP) begin
            st_d = ST_IDLE; ev_ok_o = 1'b1;
          end else begin
            idx_d = idx_q + 1'b1;
          end
        end
      end
      ST_ESTOP: begin
        if (kill_i) begin
          st_d = ST_IDLE; ev_fail_o = 1'b1;
        end else if (phy_done_i) begin
          st_d = ST_IDLE; ev_dev_o = 1'b1;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_IDLE;
      idx_q <= '0;
    end else begin
      st_q  <= st_d;
      idx_q <= idx_d;
    end
  end

  assign busy_o     = (st_q != ST_IDLE);
  assign phy_req_o  = (run && !unsup) || (st_q == ST_ESTOP);
  assign phy_op_o   = (st_q == ST_ESTOP) ? PHY_STOP : cur.op;
  assign phy_last_o = run && (cur.op == PHY_RD) && cur.last;

  always_comb begin
    phy_wdata_o = '0;
    if (run && cur.op == PHY_WR) begin
      case (cur.src)
        SRC_ADDR:   phy_wdata_o = adr_i;
        SRC_ADDR_W: phy_wdata_o = {adr_i[DW-1:1], 1'b0};
        SRC_ADDR_R: phy_wdata_o = {adr_i[DW-1:1], 1'b1};
        SRC_CMD:    phy_wdata_o = cmd_i;
        SRC_D0:     phy_wdata_o = d0_i;
        default:    phy_wdata_o = d1_i;
      endcase
    end
  end

  assign rd_ok      = run && !kill_i && !unsup && phy_done_i && !phy_arb_lost_i && (cur.op == PHY_RD);
  assign cap0_o     = rd_ok && (cur.src == SRC_D0);
  assign cap1_o     = rd_ok && (cur.src == SRC_D1);
  assign cap_data_o = phy_rdata_i;

  p_req_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phy_req_o && !phy_done_i && !kill_i) |=> (phy_req_o && $stable(phy_op_o) && $stable(phy_wdata_o)));
  p_unsup_quiet_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && unsup) |-> !phy_req_o);
  p_arb_ends_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phy_req_o && phy_done_i && phy_arb_lost_i && !kill_i) |=> !busy_o);
endmodule

// File: rtl/smbh_host.sv
module smbh_host
  import smbh_pkg::*;
#(
  parameter int unsigned DW = 8,
  parameter int unsigned AW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          reg_we_i,
  input  logic [AW-1:0] reg_addr_i,
  input  logic [DW-1:0] reg_wdata_i,
  output logic [DW-1:0] reg_rdata_o,
  output logic          phy_req_o,
  output logic [1:0]    phy_op_o,
  output logic [DW-1:0] phy_wdata_o,
  output logic          phy_last_o,
  input  logic          phy_done_i,
  input  logic          phy_nack_i,
  input  logic          phy_arb_lost_i,
  input  logic [DW-1:0] phy_rdata_i
);
  logic              busy, start, kill;
  logic              ev_ok, ev_dev, ev_bus, ev_fail, cap0, cap1;
  logic [DW-1:0]     cap_data, adr, cmd, d0, d1, stat;
  logic [KIND_W-1:0] kind;

  smbh_regs #(.DW(DW), .AW(AW)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .we_i       (reg_we_i),
    .addr_i     (reg_addr_i),
    .wdata_i    (reg_wdata_i),
    .rdata_o    (reg_rdata_o),
    .busy_i     (busy),
    .ev_ok_i    (ev_ok),
    .ev_dev_i   (ev_dev),
    .ev_bus_i   (ev_bus),
    .ev_fail_i  (ev_fail),
    .cap0_i     (cap0),
    .cap1_i     (cap1),
    .cap_data_i (cap_data),
    .start_o    (start),
    .kill_o     (kill),
    .kind_o     (kind),
    .adr_o      (adr),
    .cmd_o      (cmd),
    .d0_o       (d0),
    .d1_o       (d1),
    .stat_o     (stat)
  );

  smbh_seq #(.DW(DW)) u_seq (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .start_i        (start),
    .kill_i         (kill),
    .kind_i         (kind),
    .adr_i          (adr),
    .cmd_i          (cmd),
    .d0_i           (d0),
    .d1_i           (d1),
    .phy_req_o      (phy_req_o),
    .phy_op_o       (phy_op_o),
    .phy_wdata_o    (phy_wdata_o),
    .phy_last_o     (phy_last_o),
    .phy_done_i     (phy_done_i),
    .phy_nack_i     (phy_nack_i),
    .phy_arb_lost_i (phy_arb_lost_i),
    .phy_rdata_i    (phy_rdata_i),
    .busy_o         (busy),
    .ev_ok_o        (ev_ok),
    .ev_dev_o       (ev_dev),
    .ev_bus_o       (ev_bus),
    .ev_fail_o      (ev_fail),
    .cap0_o         (cap0),
    .cap1_o         (cap1),
    .cap_data_o     (cap_data)
  );

  p_idle_quiet_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy |-> !phy_req_o);
  p_ok_on_fall_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(stat[1]) |-> $fell(busy));
  p_dev_not_ok_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(stat[2]) |-> !$rose(stat[1]));
  p_kill_stops_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && kill) |=> (!busy && !phy_req_o && stat[4]));
endmodule

// File: tb/smbh_host_tb.sv
`timescale 1ns/1ps
module smbh_host_tb;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       reg_we_i = 1'b0;
  logic [3:0] reg_addr_i = '0;
  logic [7:0] reg_wdata_i = '0;
  logic [7:0] reg_rdata_o;
  logic       phy_req_o, phy_last_o;
  logic [1:0] phy_op_o;
  logic [7:0] phy_wdata_o;
  logic       phy_done_i = 1'b0, phy_nack_i = 1'b0, phy_arb_lost_i = 1'b0;
  logic [7:0] phy_rdata_i = '0;

  smbh_host u_dut (.*);

  always #2 clk_i = ~clk_i;

  int    total = 0, bad = 0;
  int    exp_q[$];
  bit    exp_active = 0;
  int    resp_lat = 0, nack_at = -1, arb_at = -1, op_idx = 0, rd_cnt = 0;
  int    r_b0 = 0, r_b1 = 0;
  bit    pend = 0;
  int    cnt = 0;
  string cur_req = "R1";
  bit    ended = 0;

  function automatic int enc(int op, int last, int data);
    return op * 512 + last * 256 + data;
  endfunction

  task automatic chk(string req, int got, int exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%0h exp=%0h", req, got, exp);
    end
  endtask

  // bit-level engine model and per-clock comparison against the expected phase list
  always @(negedge clk_i) begin
    phy_done_i = 0; phy_nack_i = 0; phy_arb_lost_i = 0;
    total++;
    if (!exp_active && phy_req_o) begin
      bad++;
      $display("FAIL %s got=req exp=idle", cur_req);
    end
    if (!phy_req_o) pend = 0;
    else if (!pend) begin
      int got;
      got = enc(phy_op_o, phy_last_o, (phy_op_o == 2'd1) ? phy_wdata_o : 0);
      total++;
      if (exp_q.size() == 0) begin
        bad++;
        $display("FAIL %s got=%0h exp=none", cur_req, got);
      end else begin
        int e;
        e = exp_q.pop_front();
        if (e != got) begin
          bad++;
          $display("FAIL %s got=%0h exp=%0h", cur_req, got, e);
        end
      end
      pend = 1; cnt = resp_lat;
    end
    if (pend) begin
      if (cnt == 0) begin
        phy_done_i = 1;
        if (op_idx == nack_at) phy_nack_i = 1;
        if (op_idx == arb_at) phy_arb_lost_i = 1;
        if (phy_op_o == 2'd2) begin
          phy_rdata_i = (rd_cnt == 0) ? r_b0[7:0] : r_b1[7:0];
          rd_cnt++;
        end
        op_idx++;
        pend = 0;
      end else cnt--;
    end
  end

  task automatic wr(input int a, input int d);
    @(negedge clk_i);
    reg_we_i = 1; reg_addr_i = a[3:0]; reg_wdata_i = d[7:0];
    @(negedge clk_i);
    reg_we_i = 0;
  endtask

  task automatic rd(input int a, output int v);
    @(negedge clk_i);
    reg_addr_i = a[3:0];
    #0.5;
    v = reg_rdata_o;
  endtask

  int exp_stat;

  task automatic xact_start(int kind, int rdb, int a7, int cmd, int d0, int d1,
                            int nk, int ab, int b0, int b1, int lat, string req);
    int ops[$];
    int ab0, ab1, aa;
    int v;
    aa  = (a7 << 1) | rdb;
    ab0 = a7 << 1;
    ab1 = (a7 << 1) | 1;
    cur_req = req;
    if (kind <= 3) ops.push_back(enc(0, 0, 0));
    case (kind)
      0: ops.push_back(enc(1, 0, aa));
      1: if (rdb == 0) begin
           ops.push_back(enc(1, 0, aa)); ops.push_back(enc(1, 0, cmd));
         end else begin
           ops.push_back(enc(1, 0, aa)); ops.push_back(enc(2, 1, 0));
         end
      2, 3: if (rdb == 0) begin
           ops.push_back(enc(1, 0, aa)); ops.push_back(enc(1, 0, cmd));
           ops.push_back(enc(1, 0, d0));
           if (kind == 3) ops.push_back(enc(1, 0, d1));
         end else begin
           ops.push_back(enc(1, 0, ab0)); ops.push_back(enc(1, 0, cmd));
           ops.push_back(enc(0, 0, 0)); ops.push_back(enc(1, 0, ab1));
           ops.push_back(enc(2, (kind == 2) ? 1 : 0, 0));
           if (kind == 3) ops.push_back(enc(2, 1, 0));
         end
      default: ;
    endcase
    if (kind <= 3) ops.push_back(enc(3, 0, 0));
    exp_q.delete();
    for (int i = 0; i < ops.size(); i++) begin
      if (nk >= 0 && i > nk) break;
      if (ab >= 0 && i > ab) break;
      exp_q.push_back(ops[i]);
    end
    if (nk >= 0) exp_q.push_back(enc(3, 0, 0));
    if (kind > 3 || nk >= 0) exp_stat = 8'h04;
    else if (ab >= 0) exp_stat = 8'h08;
    else exp_stat = 8'h02;
    nack_at = nk; arb_at = ab; r_b0 = b0; r_b1 = b1; rd_cnt = 0; op_idx = 0; resp_lat = lat;
    wr(4, aa); wr(3, cmd); wr(5, d0); wr(6, d1);
    exp_active = 1;
    wr(2, 8'h40 | (kind << 2));
    rd(2, v);
    chk({req, "/R3 ctrl"}, v, kind << 2);
  endtask

  task automatic xact_end(int kind, int rdb, int d0, int d1, int b0, int b1, string req);
    int v;
    for (int i = 0; i < 400; i++) begin
      rd(0, v);
      if (v[0] == 0) break;
    end
    exp_active = 0;
    chk({req, " status"}, v, exp_stat);
    chk({req, " phases left"}, exp_q.size(), 0);
    if (exp_stat == 8'h02) begin
      rd(5, v);
      chk({req, " data0"}, v, (rdb && kind >= 1 && kind <= 3) ? b0 : d0);
      rd(6, v);
      chk({req, " data1"}, v, (rdb && kind == 3) ? b1 : d1);
    end
    wr(0, 8'h1E);
    rd(0, v);
    chk("R11 clear", v, 0);
  endtask

  task automatic xact(int kind, int rdb, int a7, int cmd, int d0, int d1,
                      int nk, int ab, int b0, int b1, int lat, string req);
    xact_start(kind, rdb, a7, cmd, d0, d1, nk, ab, b0, b1, lat, req);
    xact_end(kind, rdb, d0, d1, b0, b1, req);
  endtask

  initial begin
    int v;
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    rd(0, v); chk("R1 status", v, 0);
    rd(2, v); chk("R1 ctrl", v, 0);
    chk("R1 req", phy_req_o, 0);

    wr(4, 8'hA7); wr(3, 8'h5C); wr(5, 8'h11); wr(6, 8'hEE);
    rd(4, v); chk("R2 addr", v, 8'hA7);
    rd(3, v); chk("R2 cmd", v, 8'h5C);
    rd(5, v); chk("R2 data0", v, 8'h11);
    rd(6, v); chk("R2 data1", v, 8'hEE);
    rd(7, v); chk("R2 hole7", v, 0);
    rd(8, v); chk("R2 hole8", v, 0);
    rd(12, v); chk("R2 hole12", v, 0);

    xact(0, 0, 8'h2A, 8'h00, 8'h00, 8'h00, -1, -1, 0, 0, 0, "R5 quick");
    xact(0, 1, 8'h15, 8'h00, 8'h00, 8'h00, -1, -1, 0, 0, 1, "R6 quick rd");
    xact(1, 0, 8'h50, 8'h9A, 8'h00, 8'h00, -1, -1, 0, 0, 2, "R5 byte");
    xact(1, 1, 8'h50, 8'h00, 8'h00, 8'h00, -1, -1, 8'hA5, 0, 2, "R6 byte rd");
    xact(2, 0, 8'h33, 8'h21, 8'h7E, 8'h00, -1, -1, 0, 0, 3, "R5 bdata");
    xact(2, 1, 8'h33, 8'h21, 8'h00, 8'h00, -1, -1, 8'hC3, 0, 1, "R6 bdata rd");
    xact(3, 0, 8'h48, 8'h06, 8'hBE, 8'hEF, -1, -1, 0, 0, 0, "R5 word");
    xact(3, 1, 8'h48, 8'h06, 8'h00, 8'h00, -1, -1, 8'h34, 8'h12, 2, "R6 word rd");
    xact(2, 0, 8'h7F, 8'h01, 8'h02, 8'h00, 1, -1, 0, 0, 1, "R8 nack addr");
    xact(3, 0, 8'h10, 8'h01, 8'h02, 8'h03, 3, -1, 0, 0, 0, "R8 nack data");
    xact(3, 1, 8'h10, 8'h01, 8'h00, 8'h00, 4, -1, 0, 0, 1, "R8 nack raddr");
    xact(3, 0, 8'h22, 8'h01, 8'h02, 8'h03, -1, 2, 0, 0, 1, "R9 arb");
    xact(1, 1, 8'h22, 8'h00, 8'h00, 8'h00, -1, 0, 0, 0, 0, "R9 arb start");
    xact(4, 0, 8'h22, 8'h00, 8'h00, 8'h00, -1, -1, 0, 0, 0, "R12 code10");
    xact(5, 0, 8'h22, 8'h00, 8'h00, 8'h00, -1, -1, 0, 0, 0, "R12 code14");

    // R4: start and register writes while busy are dropped
    xact_start(3, 0, 8'h41, 8'h0A, 8'h0B, 8'h0C, -1, -1, 0, 0, 8, "R4 busy");
    rd(0, v); chk("R4 busy bit", v, 8'h01);
    wr(2, 8'h44);
    wr(4, 8'h99);
    rd(4, v); chk("R4 addr kept", v, 8'h82);
    xact_end(3, 0, 8'h0B, 8'h0C, 0, 0, "R4 busy");
    rd(2, v); chk("R4 kind kept", v, 8'h0C);

    // R10: kill in flight
    cur_req = "R10 kill";
    resp_lat = 40; nack_at = -1; arb_at = -1; op_idx = 0;
    exp_q.delete(); exp_q.push_back(enc(0, 0, 0));
    exp_active = 1;
    wr(2, 8'h4C);
    repeat (4) @(negedge clk_i);
    wr(2, 8'h02);
    chk("R10 req dropped", phy_req_o, 0);
    exp_active = 0;
    rd(0, v); chk("R10 failed", v, 8'h10);
    chk("R10 phases left", exp_q.size(), 0);
    wr(0, 8'h10);
    rd(0, v); chk("R10 clear", v, 0);
    wr(2, 8'h02);
    rd(0, v); chk("R10 idle kill", v, 0);
    rd(2, v); chk("R10 idle ctrl", v, 8'h0C);

    // R11: selective clear and busy bit not writable
    xact_start(4, 0, 8'h22, 8'h00, 8'h00, 8'h00, -1, -1, 0, 0, 0, "R11 setup");
    repeat (3) @(negedge clk_i);
    exp_active = 0;
    wr(0, 8'h03);
    rd(0, v); chk("R11 keep dev", v, 8'h04);
    wr(0, 8'h04);
    rd(0, v); chk("R11 clear dev", v, 0);
    wr(0, 8'h01);
    rd(0, v); chk("R11 busy ro", v, 0);

    if (!ended) begin
      ended = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!ended) begin
      ended = 1;
      bad++;
      $display("FAIL watchdog got=timeout exp=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule